// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches a bank of already-synchronized GPIO pins and turns selected transitions into interrupt requests. Every pin carries two independent detection enables, one for low-to-high and one for high-to-low transitions. Software turns them on and off through separate write-one ports. Both may be on at once so that either transition is caught. The pin direction does not matter: a pin that the chip drives is observed in the same way as one it receives.

Each detected transition latches a bit in a status vector. The bit stays set until software writes a one to it. The bank is split into groups of 16 pins. Each group drives one level-sensitive request toward the system interrupt controller. A request is high while any status bit of its group is set and the group's bank enable is on. Clearing a bank enable hides the request, but status bits keep latching behind it.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all rising enables, falling enables, status bits and bank enables are 0, and both requests are low.
- R2: A one on a set port turns on the matching enable bit at the next clock edge. A one on a clear port turns it off. Zero bits leave the enable unchanged. If the same bit is both set and cleared in one cycle, it ends up off. The readback outputs show the current enable state.
- R3: A pin sampled as 1 after being 0 on the previous edge sets its status bit at that edge, provided its rising enable is on. A pin sampled as 0 after 1 does the same when its falling enable is on.
- R4: A status bit is never set without a transition on its pin whose direction is enabled.
- R5: A one in the status clear vector clears that status bit. Zero bits leave status unchanged.
- R6: If a transition is detected on a bit in the same cycle that the bit is cleared, the bit stays set.
- R7: Request bit 0 reflects status bits 15..0 and request bit 1 reflects status bits 31..16. A request stays high until every status bit of its group is cleared.
- R8: While a group's bank enable (bank_en bit g for group g) is 0, that group's request stays low, but status still latches. Setting the enable raises the request for bits that are already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| rise_set_i | input | 32 | Write-one: turn on rising detection |
| rise_clr_i | input | 32 | Write-one: turn off rising detection |
| fall_set_i | input | 32 | Write-one: turn on falling detection |
| fall_clr_i | input | 32 | Write-one: turn off falling detection |
| stat_clr_i | input | 32 | Write-one-to-clear for status bits |
| bank_we_i | input | 1 | Write strobe for bank enables |
| bank_d_i | input | 2 | New bank enable value |
| rise_en_o | output | 32 | Rising enable readback |
| fall_en_o | output | 32 | Falling enable readback |
| status_o | output | 32 | Latched transition status |
| bank_en_o | output | 2 | Bank enable readback |
| irq_o | output | 2 | Level request per 16-pin group |

## Verification
A detected transition and a software clear can land on the same status bit in the same clock cycle. The bench provokes this by first latching a bit. It then raises that pin again in the very cycle the clear vector targets it, and expects the bit to remain set. A plain clear in the next cycle must then remove it. The same style of collision is used on the enable registers: a bit is set and cleared together and is expected to read back as off.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 32,
  parameter int GRP = 16,
  localparam int NGRP = NPINS / GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] rise_set_i,
  input  logic [NPINS-1:0] rise_clr_i,
  input  logic [NPINS-1:0] fall_set_i,
  input  logic [NPINS-1:0] fall_clr_i,
  input  logic [NPINS-1:0] stat_clr_i,
  input  logic             bank_we_i,
  input  logic [NGRP-1:0]  bank_d_i,
  output logic [NPINS-1:0] rise_en_o,
  output logic [NPINS-1:0] fall_en_o,
  output logic [NPINS-1:0] status_o,
  output logic [NGRP-1:0]  bank_en_o,
  output logic [NGRP-1:0]  irq_o
);

  logic [NPINS-1:0] rise_q, fall_q, stat_q, prev_q, hit;
  logic [NGRP-1:0]  bank_q;

  assign hit = (pin_i & ~prev_q & rise_q) | (~pin_i & prev_q & fall_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
      bank_q <= '0;
    end else begin
      rise_q <= (rise_q | rise_set_i) & ~rise_clr_i;
      fall_q <= (fall_q | fall_set_i) & ~fall_clr_i;
      stat_q <= (stat_q & ~stat_clr_i) | hit;
      prev_q <= pin_i;
      if (bank_we_i) bank_q <= bank_d_i;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : grp
    assign irq_o[g] = bank_q[g] & (|stat_q[g*GRP +: GRP]);

    assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |=> irq_o[g] || $past(|stat_clr_i[g*GRP +: GRP]) || $past(bank_we_i));
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign status_o  = stat_q;
  assign bank_en_o = bank_q;

  assert_rise_en_by_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_q ^ $past(rise_q)) & ~$past(rise_set_i | rise_clr_i)) == '0);

  assert_fall_en_by_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_q ^ $past(fall_q)) & ~$past(fall_set_i | fall_clr_i)) == '0);

  assert_set_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q)) & ~($past(pin_i) ^ $past(prev_q))) == '0);

  assert_clear_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_q & $past(stat_q)) & ~$past(stat_clr_i)) == '0);

endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pin_i = 0, rise_set_i = 0, rise_clr_i = 0, fall_set_i = 0, fall_clr_i = 0, stat_clr_i = 0;
  logic        bank_we_i = 0;
  logic [1:0]  bank_d_i = 0;
  logic [31:0] rise_en_o, fall_en_o, status_o;
  logic [1:0]  bank_en_o, irq_o;
  int nerr = 0, nchk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_irq u0 (.*);

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    rise_set_i = 0; rise_clr_i = 0; fall_set_i = 0; fall_clr_i = 0;
    stat_clr_i = 0; bank_we_i = 0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bank(logic [1:0] v);
    bank_we_i = 1; bank_d_i = v; cyc();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] b;
    logic [1:0]  g;
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 rise_en", rise_en_o, 0);
    chk("R1 fall_en", fall_en_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 bank/irq", {28'd0, bank_en_o, irq_o}, 0);

    // R2 set / clear ports, zeros no effect, clear wins
    rise_set_i = 32'hA5A5_0F0F; fall_set_i = 32'h1234_5678; cyc();
    chk("R2 rise set", rise_en_o, 32'hA5A5_0F0F);
    chk("R2 fall set", fall_en_o, 32'h1234_5678);
    rise_clr_i = 32'h0000_000F; fall_set_i = 32'h8000_0000; fall_clr_i = 32'h8000_0008; cyc();
    chk("R2 rise clr", rise_en_o, 32'hA5A5_0F00);
    chk("R2 set+clr same bit", fall_en_o, 32'h1234_5670);
    rise_clr_i = '1; fall_clr_i = '1; cyc();
    chk("R2 clear all", rise_en_o | fall_en_o, 0);

    // R3/R4/R7 sweep: every pin, every enable mode, both directions
    bank(2'b11);
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        b = 32'd1 << p;
        g = (p < 16) ? 2'b01 : 2'b10;
        rise_clr_i = '1; fall_clr_i = '1; cyc();
        rise_set_i = m[0] ? b : 0; fall_set_i = m[1] ? b : 0; cyc();
        stat_clr_i = '1; cyc();
        pin_i = b; cyc();
        chk("R3 rising", status_o, m[0] ? b : 0);
        chk("R7 group rise", {30'd0, irq_o}, m[0] ? {30'd0, g} : 0);
        stat_clr_i = '1; cyc();
        chk("R4 no edge no set", status_o, 0);
        pin_i = 0; cyc();
        chk("R3 falling", status_o, m[1] ? b : 0);
        chk("R7 group fall", {30'd0, irq_o}, m[1] ? {30'd0, g} : 0);
      end
    end
    stat_clr_i = '1; rise_clr_i = '1; fall_clr_i = '1; cyc();

    // R7 level held until all group bits cleared
    rise_set_i = 32'h0010_0204; cyc();
    pin_i = 32'h0010_0204; cyc();
    chk("R7 latched", status_o, 32'h0010_0204);
    stat_clr_i = 32'h0000_0004; cyc();
    chk("R5 partial clear", status_o, 32'h0010_0200);
    chk("R7 low held", {30'd0, irq_o}, 3);
    stat_clr_i = 32'h0000_0200; cyc();
    chk("R7 low dropped", {30'd0, irq_o}, 2);
    stat_clr_i = 32'h0010_0000; cyc();
    chk("R7 high dropped", {30'd0, irq_o}, 0);
    pin_i = 0; cyc();

    // R8 bank enable masks output, not latching
    bank(2'b10);
    pin_i = 32'h0000_0004; cyc();
    chk("R8 latched while masked", status_o, 32'h0000_0004);
    chk("R8 irq masked", {30'd0, irq_o}, 0);
    bank(2'b01);
    chk("R8 pending shown", {30'd0, irq_o}, 1);
    chk("R8 readback", {30'd0, bank_en_o}, 1);
    stat_clr_i = '1; pin_i = 0; cyc();

    // R6 edge and clear collide
    rise_clr_i = '1; rise_set_i = 0; cyc();
    rise_set_i = 32'h0000_0020; cyc();
    pin_i = 32'h0000_0020; cyc();
    pin_i = 0; cyc();
    chk("R6 pre-set", status_o, 32'h0000_0020);
    pin_i = 32'h0000_0020; stat_clr_i = 32'h0000_0020; cyc();
    chk("R6 edge wins", status_o, 32'h0000_0020);
    stat_clr_i = 32'h0000_0000; cyc();
    chk("R5 zero clear no effect", status_o, 32'h0000_0020);
    stat_clr_i = 32'h0000_0020; cyc();
    chk("R5 clear", status_o, 0);
    chk("R7 idle", {30'd0, irq_o}, 0);

    summary();
  end
endmodule